// File: doc/BRIEF.md
# Branch Target and Link Resolver

This block turns a resolved branch of a 32-bit core into its architectural effects. It takes the address of the branch, a sign-extended immediate displacement, a register operand, a flag saying that the branch's condition has passed, and a two-bit branch kind. From these it produces the next fetch address, a link-register write strobe with the return address, and the instruction-set state bit. The evaluation of the condition codes, the pipeline flush and the fetch itself are handled elsewhere.

Four kinds are handled. Two compute a pc-relative target; one of them also records a return address. Two take the target from the register operand: bit 0 of that operand chooses the new instruction-set state and is cleared from the address. The linking exchange kind can also use a pc-relative target, chosen by a select input, and in that form it flips the state bit. All results are registered, so they appear one clock after the branch is presented with `issue_i` high.

Top module: `br_resolve`

## Requirements
- R1: While `rst_ni` is low, `next_pc_o` is 0, `isa_o` is 0, `lnk_we_o` is 0 and `lnk_val_o` is 0.
- R2: With `kind_i`=00 (relative) and a passed condition, `next_pc_o` becomes `pc_i + 4*off_i` modulo 2^32, `off_i` being two's complement; `isa_o` keeps its value and `lnk_we_o` stays 0.
- R3: With `kind_i`=01 (relative with link) and a passed condition, the target is as in R2, `isa_o` keeps its value, `lnk_we_o` is 1 and `lnk_val_o` is `pc_i + 4`.
- R4: With `kind_i`=10 (register exchange) and a passed condition, `next_pc_o` is `reg_i` with bit 0 forced to 0, `isa_o` takes `reg_i[0]`, and `lnk_we_o` stays 0.
- R5: With `kind_i`=11 and `src_reg_i`=1 and a passed condition, target and state are as in R4, `lnk_we_o` is 1 and `lnk_val_o` is `pc_i + 4`.
- R6: With `kind_i`=11 and `src_reg_i`=0 and a passed condition, the target is as in R2, `isa_o` is inverted, `lnk_we_o` is 1 and `lnk_val_o` is `pc_i + 4`.
- R7: When `cond_i` is 0, for every kind, `next_pc_o` becomes `pc_i + 4`, `isa_o` keeps its value, `lnk_we_o` is 0 and `lnk_val_o` keeps its value.
- R8: `src_reg_i` has no effect for kinds 00, 01 and 10.
- R9: In a cycle with `issue_i` low, `next_pc_o`, `isa_o` and `lnk_val_o` keep their values and `lnk_we_o` returns to 0, so the strobe lasts one cycle per issued branch.
- R10: Results appear on the outputs after the first rising clock edge at which `issue_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | A branch is presented this cycle |
| kind_i | input | 2 | Branch kind: 00 relative, 01 relative with link, 10 register exchange, 11 exchange with link |
| src_reg_i | input | 1 | For kind 11: 1 selects the register target, 0 the relative target |
| cond_i | input | 1 | Condition of the branch has passed |
| pc_i | input | 32 | Address of the branch |
| off_i | input | 32 | Sign-extended displacement in words |
| reg_i | input | 32 | Register operand for the exchange kinds |
| next_pc_o | output | 32 | Next fetch address |
| lnk_we_o | output | 1 | Link register write strobe |
| lnk_val_o | output | 32 | Return address to write |
| isa_o | output | 1 | Instruction-set state bit |

## Verification
Every kind is tried with the condition passed and failed and with both values of the source select, over a grid of branch addresses (low, mid-range and near the top so the sum wraps), displacements (zero, positive, minus one and a large negative value) and register operands with bit 0 set and clear. The zero displacement separates a shifted add from a plain copy of the pc, the negative and wrapping cases catch a missing sign extension or truncation, and the odd and even register operands show that bit 0 is both stripped from the address and moved into the state bit. The state bit is tracked across the whole sweep, so the inversion of the immediate exchange form and the holding on failed conditions are checked against the accumulated history, and an idle cycle after each branch shows that the link strobe drops and the rest holds.

// File: rtl/brres_pkg.sv
package brres_pkg;

    localparam int unsigned ADDR_W = 32;

    typedef enum logic [1:0] {
        BK_REL     = 2'b00,
        BK_REL_LNK = 2'b01,
        BK_XCH     = 2'b10,
        BK_XCH_LNK = 2'b11
    } br_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              lnk_we;
        logic [ADDR_W-1:0] lnk_val;
        logic              isa;
    } br_state_t;

endpackage

// File: rtl/br_tgt_calc.sv
module br_tgt_calc
    import brres_pkg::*;
#(
    parameter int unsigned W     = ADDR_W,
    parameter int unsigned SHIFT = 2
) (
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] off_i,
    input  logic [W-1:0] reg_i,
    input  br_kind_e     kind_i,
    input  logic         src_reg_i,
    input  logic         isa_cur_i,
    output logic [W-1:0] tgt_o,
    output logic         isa_nxt_o
);
    logic [W-1:0] rel_tgt;
    logic [W-1:0] xch_tgt;

    assign rel_tgt = pc_i + (off_i << SHIFT);
    assign xch_tgt = {reg_i[W-1:1], 1'b0};

    always_comb begin
        tgt_o     = rel_tgt;
        isa_nxt_o = isa_cur_i;
        unique case (kind_i)
            BK_REL, BK_REL_LNK: begin
                tgt_o     = rel_tgt;
                isa_nxt_o = isa_cur_i;
            end
            BK_XCH: begin
                tgt_o     = xch_tgt;
                isa_nxt_o = reg_i[0];
            end
            BK_XCH_LNK: begin
                if (src_reg_i) begin
                    tgt_o     = xch_tgt;
                    isa_nxt_o = reg_i[0];
                end else begin
                    tgt_o     = rel_tgt;
                    isa_nxt_o = ~isa_cur_i;
                end
            end
            default: begin
                tgt_o     = rel_tgt;
                isa_nxt_o = isa_cur_i;
            end
        endcase
    end

    // R4
    always_comb begin
        if (kind_i == BK_XCH) begin
            xch_even_chk: assert (tgt_o[0] == 1'b0);
        end
    end
endmodule

// File: rtl/br_link_calc.sv
module br_link_calc
    import brres_pkg::*;
#(
    parameter int unsigned W    = ADDR_W,
    parameter int unsigned STEP = 4
) (
    input  logic [W-1:0] pc_i,
    input  br_kind_e     kind_i,
    output logic [W-1:0] seq_pc_o,
    output logic         lnk_req_o
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    assign seq_pc_o = pc_i + STEP_V;

    always_comb begin
        unique case (kind_i)
            BK_REL_LNK, BK_XCH_LNK: lnk_req_o = 1'b1;
            default:                lnk_req_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
    import brres_pkg::*;
#(
    parameter int unsigned  W        = ADDR_W,
    parameter int unsigned  SHIFT    = 2,
    parameter int unsigned  STEP     = 4,
    parameter logic [W-1:0] RESET_PC = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         issue_i,
    input  logic [1:0]   kind_i,
    input  logic         src_reg_i,
    input  logic         cond_i,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] off_i,
    input  logic [W-1:0] reg_i,
    output logic [W-1:0] next_pc_o,
    output logic         lnk_we_o,
    output logic [W-1:0] lnk_val_o,
    output logic         isa_o
);
    typedef struct packed {
        logic [W-1:0] pc;
        logic         lnk_we;
        logic [W-1:0] lnk_val;
        logic         isa;
    } res_t;

    localparam res_t RES_RST = '{pc: RESET_PC, lnk_we: 1'b0, lnk_val: '0, isa: 1'b0};

    br_kind_e     kind;
    logic [W-1:0] tgt;
    logic         isa_nxt;
    logic [W-1:0] seq_pc;
    logic         lnk_req;
    res_t         res_d;
    res_t         res_q;

    assign kind = br_kind_e'(kind_i);

    br_tgt_calc #(.W(W), .SHIFT(SHIFT)) u_tgt (
        .pc_i      (pc_i),
        .off_i     (off_i),
        .reg_i     (reg_i),
        .kind_i    (kind),
        .src_reg_i (src_reg_i),
        .isa_cur_i (res_q.isa),
        .tgt_o     (tgt),
        .isa_nxt_o (isa_nxt)
    );

    br_link_calc #(.W(W), .STEP(STEP)) u_lnk (
        .pc_i      (pc_i),
        .kind_i    (kind),
        .seq_pc_o  (seq_pc),
        .lnk_req_o (lnk_req)
    );

    always_comb begin
        res_d        = res_q;
        res_d.lnk_we = 1'b0;
        if (issue_i) begin
            if (cond_i) begin
                res_d.pc  = tgt;
                res_d.isa = isa_nxt;
                if (lnk_req) begin
                    res_d.lnk_we  = 1'b1;
                    res_d.lnk_val = seq_pc;
                end
            end else begin
                res_d.pc = seq_pc;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= RES_RST;
        end else begin
            res_q <= res_d;
        end
    end

    assign next_pc_o = res_q.pc;
    assign lnk_we_o  = res_q.lnk_we;
    assign lnk_val_o = res_q.lnk_val;
    assign isa_o     = res_q.isa;

    // R9
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue_i |=> ($stable(next_pc_o) && $stable(isa_o) && !lnk_we_o));

    // R7
    cond_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && !cond_i) |=> (next_pc_o == $past(pc_i) + W'(STEP) && !lnk_we_o && $stable(isa_o)));

    // R3
    lnk_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lnk_we_o |-> ($past(issue_i) && $past(cond_i) && $past(kind_i[0])));

    // R4
    xch_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && cond_i && kind_i == 2'b10) |=> (isa_o == $past(reg_i[0]) && !next_pc_o[0]));

    // R2
    rel_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_i && cond_i && !kind_i[1]) |=> $stable(isa_o));
endmodule

// File: tb/tb_br_resolve.sv
module tb_br_resolve;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic        src_reg = 1'b0;
    logic        cond = 1'b0;
    logic [31:0] pc = '0;
    logic [31:0] off = '0;
    logic [31:0] rop = '0;
    logic [31:0] next_pc;
    logic        lnk_we;
    logic [31:0] lnk_val;
    logic        isa;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    br_resolve dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .issue_i   (issue),
        .kind_i    (kind),
        .src_reg_i (src_reg),
        .cond_i    (cond),
        .pc_i      (pc),
        .off_i     (off),
        .reg_i     (rop),
        .next_pc_o (next_pc),
        .lnk_we_o  (lnk_we),
        .lnk_val_o (lnk_val),
        .isa_o     (isa)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pc_pat(input int i);
        case (i)
            0: return 32'h0000_1000;
            1: return 32'h8000_0000;
            default: return 32'hFFFF_FFF0;
        endcase
    endfunction

    function automatic logic [31:0] off_pat(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0005;
            2: return 32'hFFFF_FFFF;
            default: return 32'hFFFF_FF00;
        endcase
    endfunction

    function automatic logic [31:0] reg_pat(input int i);
        case (i)
            0: return 32'h0000_2001;
            1: return 32'h0000_2000;
            2: return 32'hFFFF_FFFF;
            default: return 32'h0000_0000;
        endcase
    endfunction

    initial begin
        logic        m_isa;
        logic [31:0] m_pc;
        logic [31:0] m_lv;
        logic        m_we;
        string       tag;

        // R1: reset state
        #(CLK_PERIOD*2 + 1);
        chk("R1 next_pc", next_pc, 32'h0);
        chk("R1 isa", {31'h0, isa}, 32'h0);
        chk("R1 lnk_we", {31'h0, lnk_we}, 32'h0);
        chk("R1 lnk_val", lnk_val, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        m_isa = 1'b0;
        m_pc  = 32'h0;
        m_lv  = 32'h0;

        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 2; c++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int p = 0; p < 3; p++) begin
                        for (int o = 0; o < 4; o++) begin
                            for (int r = 0; r < 4; r++) begin
                                @(negedge clk);
                                issue = 1'b1; kind = 2'(k); cond = c[0]; src_reg = s[0];
                                pc = pc_pat(p); off = off_pat(o); rop = reg_pat(r);
                                m_we = 1'b0;
                                if (c == 0) begin
                                    tag = "R7";
                                    m_pc = pc + 32'd4;
                                end else if (k < 2) begin
                                    tag = (k == 0) ? "R2" : "R3";
                                    m_pc = pc + off * 32'd4;
                                    if (k == 1) begin m_we = 1'b1; m_lv = pc + 32'd4; end
                                end else if (k == 2) begin
                                    tag = "R4";
                                    m_pc = rop & 32'hFFFF_FFFE;
                                    m_isa = rop[0];
                                end else if (s == 1) begin
                                    tag = "R5";
                                    m_pc = rop & 32'hFFFF_FFFE;
                                    m_isa = rop[0];
                                    m_we = 1'b1; m_lv = pc + 32'd4;
                                end else begin
                                    tag = "R6";
                                    m_pc = pc + off * 32'd4;
                                    m_isa = ~m_isa;
                                    m_we = 1'b1; m_lv = pc + 32'd4;
                                end
                                if (k < 3 && s == 1) tag = {tag, "/R8"};
                                // R10: result visible just after the capturing edge
                                @(posedge clk); #1;
                                chk({tag, " R10 next_pc"}, next_pc, m_pc);
                                chk({tag, " isa"}, {31'h0, isa}, {31'h0, m_isa});
                                chk({tag, " lnk_we"}, {31'h0, lnk_we}, {31'h0, m_we});
                                chk({tag, " lnk_val"}, lnk_val, m_lv);
                                // R9: idle cycle holds state and drops the strobe
                                @(negedge clk);
                                issue = 1'b0; pc = ~pc; rop = ~rop; cond = 1'b1;
                                @(posedge clk); #1;
                                chk("R9 next_pc", next_pc, m_pc);
                                chk("R9 isa", {31'h0, isa}, {31'h0, m_isa});
                                chk("R9 lnk_we", {31'h0, lnk_we}, 32'h0);
                                chk("R9 lnk_val", lnk_val, m_lv);
                            end
                        end
                    end
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
        end
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule